// File: doc/BRIEF.md
# Serial-to-Parallel Converter with Bit Slip

This block turns a single-bit serial stream, clocked at the bit rate, into parallel words of four bits. One of two serial inputs is picked by a select pin, so that a loopback path can be switched in for testing. Every rising clock edge shifts the picked bit into a shift register. A free-running divider marks the word boundary. At that boundary the shift register's contents are copied into the parallel output register, which then holds steady until the next boundary.

The divider produces a word-rate clock (divide by four) and a frame clock (divide by eight). A mode pin stretches the update period from four to eight clocks, so that two converters can share an 8-bit word. The converter also re-emits the picked serial bit one clock later, and that output feeds the serial input of a second converter in a cascade. The serial stream is continuous and has no valid/ready handshake: the source cannot be stalled, and every clock edge consumes one bit.

Word alignment is adjusted with an asynchronous slip input. Each pulse on it makes the divider skip exactly one count, which moves the word boundary one bit later in the stream. A master reset puts every converter's divider into the same phase.

Top module: `s2p_deser`

## Requirements
- R1: With wide_mode=0, one serial bit is taken at every rising edge. par_q loads at every fourth counted edge (count values 3, 7, ...). It then holds the four bits taken at counted edges 0..3, 4..7, ... of the count, with par_q[0] the earliest bit and par_q[3] the latest.
- R2: word_clk is bit 1 and pair_clk is bit 2 of a 3-bit count of non-swallowed edges since reset. The first counted edge takes the count from 0 to 1, so word_clk has a period of 4 clocks and pair_clk a period of 8.
- R3: Between loads, par_q does not change. It is stable for 4 clocks with wide_mode=0 and for 8 clocks with wide_mode=1 when no slip occurs.
- R4: With wide_mode=1, par_q loads only at edges where the count is 7. It holds the four bits taken at counts 4..7, with par_q[0] the earliest.
- R5: After each rising edge, ser_out equals the serial bit that was picked at that edge.
- R6: pick_a=1 selects ser_a and pick_a=0 selects ser_b. The input that is not selected has no effect on par_q or ser_out.
- R7: slip is asynchronous and passes through a two-flop synchronizer. If slip is first sampled high at edge k, the count does not advance at edge k+2 and no word loads at that edge. Every later word boundary moves one bit later in the stream.
- R8: A slip pulse held high for two or more clocks causes exactly one skipped count, however long it lasts. A further slip needs a new pulse.
- R9: Asserting arst_n low clears the count, the shift register, par_q and ser_out at once, without waiting for a clock. Release passes through a two-flop synchronizer, and the third rising edge after release is the first counted edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| arst_n | input | 1 | Master reset, active low, asynchronous assert |
| pick_a | input | 1 | 1 selects ser_a, 0 selects ser_b |
| ser_a | input | 1 | Serial data input A |
| ser_b | input | 1 | Serial data input B (loopback path) |
| slip | input | 1 | Asynchronous word-boundary slip request |
| wide_mode | input | 1 | 0: update every 4 clocks, 1: update every 8 clocks |
| par_q | output | 4 | Parallel word, bit 0 is the earliest serial bit |
| ser_out | output | 1 | Selected serial bit delayed by one clock |
| word_clk | output | 1 | Divide-by-4 clock |
| pair_clk | output | 1 | Divide-by-8 clock |

## Verification
The hardest situation to reach from the ports is a slip pulse that lands at a known divider phase and is held far longer than its minimum width. Only then does the check show that the boundary moves by one bit and not by several. The stimulus raises slip at chosen edges of a fresh run after reset, holding it for six clocks in 4-clock mode and for two clocks in 8-clock mode. A reference count in the bench skips the edge two clocks after slip is first sampled. The bench checks every following word, both frame clocks and the hold between loads against that shifted boundary.

// File: rtl/s2p_pkg.sv
package s2p_pkg;

  // Width of the divider count: one full frame of two words.
  function automatic int cnt_width(input int word_w);
    return $clog2(2 * word_w);
  endfunction

  // Next value of a shift register that takes its new bit at the top,
  // so that the earliest bit ends up in bit 0.
  function automatic logic [63:0] shift_in(input logic [63:0] cur, input logic din, input int width);
    logic [63:0] res;
    res = cur >> 1;
    res[width-1] = din;
    return res;
  endfunction

endpackage

// File: rtl/s2p_slip_detect.sv
module s2p_slip_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic pulse
);
  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[PIPE_W-2:0], async_in};
  end

  // Rising edge of the synchronized level: one cycle per pulse.
  assign pulse = pipe[SYNC_STAGES-1] & ~pipe[SYNC_STAGES];

  // R8: a held request never yields two back-to-back swallows
  a_r8_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && pulse) |=> !pulse);

endmodule

// File: rtl/s2p_divider.sv
module s2p_divider #(
  parameter int WORD_W = 4,
  parameter int CNT_W  = s2p_pkg::cnt_width(WORD_W)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic swallow,
  input  logic wide,
  output logic load,
  output logic word_clk,
  output logic pair_clk
);
  localparam int SUB_W = CNT_W - 1;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!swallow) cnt <= cnt + 1'b1;
  end

  assign word_clk = cnt[SUB_W-1];
  assign pair_clk = cnt[CNT_W-1];

  // Boundary at the last count of a word, or of a frame in wide mode.
  assign load = !swallow && (wide ? (&cnt) : (&cnt[SUB_W-1:0]));

  // R7: a swallowed edge leaves the count where it was
  a_r7_swallow_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && swallow) |=> (cnt == $past(cnt)));

  // R2: every other edge advances the count by one
  a_r2_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !swallow) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

endmodule

// File: rtl/s2p_shifter.sv
module s2p_shifter #(
  parameter int WORD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pick_a,
  input  logic              ser_a,
  input  logic              ser_b,
  output logic [WORD_W-1:0] next_word,
  output logic              ser_out
);
  logic              bit_in;
  logic [WORD_W-1:0] sreg;
  logic [63:0]       wide_next;

  assign bit_in    = pick_a ? ser_a : ser_b;
  assign wide_next = s2p_pkg::shift_in(64'(sreg), bit_in, WORD_W);
  assign next_word = wide_next[WORD_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg    <= '0;
      ser_out <= 1'b0;
    end else begin
      sreg    <= next_word;
      ser_out <= bit_in;
    end
  end

  // R5: the retimed serial output lags the picked input by one clock
  a_r5_ser_out_delay: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (ser_out == $past(pick_a ? ser_a : ser_b)));

endmodule

// File: rtl/s2p_deser.sv
module s2p_deser #(
  parameter int WORD_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              pick_a,
  input  logic              ser_a,
  input  logic              ser_b,
  input  logic              slip,
  input  logic              wide_mode,
  output logic [WORD_W-1:0] par_q,
  output logic              ser_out,
  output logic              word_clk,
  output logic              pair_clk
);
  logic [1:0]        rst_pipe;
  logic              rst_n;
  logic              swallow;
  logic              load;
  logic [WORD_W-1:0] next_word;

  // Asynchronous assert, release after two clock edges.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_pipe <= '0;
    else         rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n = rst_pipe[1];

  s2p_slip_detect #(.SYNC_STAGES(SYNC_STAGES)) u_slip (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(slip),
    .pulse   (swallow)
  );

  s2p_divider #(.WORD_W(WORD_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .swallow (swallow),
    .wide    (wide_mode),
    .load    (load),
    .word_clk(word_clk),
    .pair_clk(pair_clk)
  );

  s2p_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .pick_a   (pick_a),
    .ser_a    (ser_a),
    .ser_b    (ser_b),
    .next_word(next_word),
    .ser_out  (ser_out)
  );

  // Parallel register takes the word including the bit arriving this edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    par_q <= '0;
    else if (load) par_q <= next_word;
  end

  // R3: the parallel word only moves at a boundary
  a_r3_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !load) |=> $stable(par_q));

  // R7: a swallowed edge is never a word boundary
  a_r7_no_load_on_swallow: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && swallow) |=> $stable(par_q));

endmodule

// File: tb/sim_s2p_deser.sv
module sim_s2p_deser;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic arst_n, pick_a, ser_a, ser_b, slip, wide_mode;
  logic [W-1:0] par_q;
  logic ser_out, word_clk, pair_clk;

  s2p_deser #(.WORD_W(W)) u0 (
    .clk(clk), .arst_n(arst_n), .pick_a(pick_a), .ser_a(ser_a), .ser_b(ser_b),
    .slip(slip), .wide_mode(wide_mode), .par_q(par_q), .ser_out(ser_out),
    .word_clk(word_clk), .pair_clk(pair_clk)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  typedef struct {
    int           k;
    logic [W-1:0] word;
    string        tag;
  } item_t;
  item_t sb[$];

  int cur_k = -1;
  int done_k = -1;
  logic [W-1:0] hold_word = '0;
  logic [15:0] lfsr_a = 16'hACE1;
  logic [15:0] lfsr_b = 16'h1D2B;

  always @(posedge clk) done_k <= cur_k;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops expected words at their load edge, otherwise demands a hold.
  always @(negedge clk) begin
    item_t it;
    if (done_k >= 0) begin
      if (sb.size() > 0 && sb[0].k == done_k) begin
        it = sb.pop_front();
        chk(it.tag, 32'(par_q), 32'(it.word));
        hold_word = it.word;
      end else begin
        chk("R3 hold between loads", 32'(par_q), 32'(hold_word));
      end
    end else begin
      hold_word = '0;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    cur_k = -1;
    slip = 1'b0;
    @(posedge clk);
    @(negedge clk);
    arst_n = 1'b0;
    #1;
    chk("R9 reset par_q", 32'(par_q), 32'h0);
    chk("R9 reset ser_out", 32'(ser_out), 32'h0);
    chk("R9 reset word_clk", 32'(word_clk), 32'h0);
    chk("R9 reset pair_clk", 32'(pair_clk), 32'h0);
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (2) @(posedge clk);
  endtask

  // Driver: one bit per edge, reference count and expected words into sb.
  task automatic run_phase(input int n, input bit a_sel, input bit wide,
                           input int s0, input int s1, input int slen, input string tag);
    logic [W-1:0] m_sh = '0;
    int m_cnt = 0;
    logic exp_out = 1'b0;
    logic b;
    bit sw;
    pick_a = a_sel;
    wide_mode = wide;
    for (int k = 0; k <= n; k++) begin
      @(negedge clk);
      if (k > 0) begin
        chk("R5 ser_out delay", 32'(ser_out), 32'(exp_out));
        chk("R2 word_clk", 32'(word_clk), 32'(m_cnt[1]));
        chk("R2 pair_clk", 32'(pair_clk), 32'(m_cnt[2]));
      end
      if (k == n) break;
      lfsr_a = {lfsr_a[14:0], lfsr_a[15] ^ lfsr_a[13] ^ lfsr_a[12] ^ lfsr_a[10]};
      lfsr_b = {lfsr_b[14:0], lfsr_b[15] ^ lfsr_b[13] ^ lfsr_b[12] ^ lfsr_b[10]};
      ser_a = lfsr_a[0];
      ser_b = lfsr_b[0];
      slip = (s0 >= 0 && k >= s0 && k < s0 + slen) || (s1 >= 0 && k >= s1 && k < s1 + slen);
      b = a_sel ? ser_a : ser_b;
      sw = (s0 >= 0 && k == s0 + 2) || (s1 >= 0 && k == s1 + 2);
      m_sh = {b, m_sh[W-1:1]};
      if (!sw && (wide ? (m_cnt % 8 == 7) : (m_cnt % 4 == 3)))
        sb.push_back('{k: k, word: m_sh, tag: tag});
      if (!sw) m_cnt = (m_cnt + 1) % 8;
      exp_out = b;
      cur_k = k;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    arst_n = 1'b1; pick_a = 1'b1; ser_a = 1'b0; ser_b = 1'b0; slip = 1'b0; wide_mode = 1'b0;
    #1 arst_n = 1'b0;
    // R1 word order in 4-clock mode, input A
    do_reset();
    run_phase(40, 1'b1, 1'b0, -1, -1, 0, "R1 word mode4 input A");
    // R6 loopback input B selected, A toggling but ignored
    do_reset();
    run_phase(40, 1'b0, 1'b0, -1, -1, 0, "R6 word input B");
    // R4 eight-clock update period
    do_reset();
    run_phase(48, 1'b1, 1'b1, -1, -1, 0, "R4 word mode8");
    // R7 R8 two long slip pulses, one swallow each
    do_reset();
    run_phase(60, 1'b1, 1'b0, 10, 30, 6, "R7 R8 word after long slip");
    // R7 minimum-width slip in wide mode on input B
    do_reset();
    run_phase(60, 1'b0, 1'b1, 13, -1, 2, "R7 word mode8 after slip");
    do_reset();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule